// File: doc/BRIEF.md
# Banked Cartridge Memory Controller

This block sits between a CPU bus and the ROM and RAM arrays of a banked cartridge. CPU writes that land in the lower half of the address map (0x0000–0x7FFF) do not store data. They program four control fields: a RAM gate, a five-bit low bank number, a two-bit upper bank number and a one-bit mapping mode. From these fields the block forms a physical ROM address for the fixed window (0x0000–0x3FFF) and the switchable window (0x4000–0x7FFF). It also forms a RAM address, a chip enable and a write enable for the external RAM window (0xA000–0xBFFF).

A static strap input selects the multicart layout. In that layout the low bank is four bits wide and the upper bank bits sit one position lower. Bank numbers beyond the fitted ROM or RAM wrap around, because the ROM and RAM sizes are power-of-two parameters. While the RAM is gated off, a read in the RAM window returns 0xFF and a write there has no effect.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write with address bits [15:13] = 000 controls the RAM gate. Data 0x0A opens it, data 0x00 closes it, and any other data leaves it as it was.
- R2: A write with address bits [15:13] = 001 loads the low bank from data bits [4:0]. A value of zero is replaced by one, and the result is then masked to 5 bits, or to 4 bits when the multicart strap is high. So in multicart mode the value 0x10 gives low bank 0.
- R3: A write with address bits [15:13] = 010 loads the upper bank from data bits [1:0]. The switchable-window bank is the upper bank shifted left by 5 (by 4 when multicart), ORed with the low bank, which is kept unchanged.
- R4: A write with address bits [15:13] = 011 sets the mode from data bit 0. In mode 1 the fixed window uses bank (upper << 5, or << 4 when multicart) and the RAM bank is the upper bank. In mode 0 both the fixed-window bank and the RAM bank are 0.
- R5: ROM bank numbers wrap modulo ROM_BANKS (16 KiB each), and RAM bank numbers wrap modulo RAM_BANKS (8 KiB each). Both sizes are powers of two.
- R6: After reset the low bank is 1, the upper bank is 0, the mode is 0 and the RAM gate is closed. As a result, the switchable window shows bank 1 and the RAM bank is 0.
- R7: ram_ce is high when the gate is open and a read or write addresses 0xA000–0xBFFF, and ram_we is high when ram_ce is high for a write. When the gate is closed, such an access gives no ram_ce, and a read in that window returns 0xFF on cpu_rdata. Otherwise cpu_rdata is mem_rdata.
- R8: All outputs other than cpu_rdata are registered: an access in cycle n appears after edge n. rom_addr is {bank, addr[13:0]}, where address bit 14 picks the switchable bank, and ram_addr is {RAM bank, addr[12:0]}. A control write is used by accesses from the next cycle on. A write with address bit 15 set changes no control field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| multi_en | input | 1 | Multicart layout strap, changed only in reset |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| mem_rdata | input | 8 | Byte returned by the selected array |
| rom_addr | output | ROM_AW | Physical ROM byte address |
| ram_addr | output | RAM_AW | Physical RAM byte address |
| ram_ce | output | 1 | RAM chip enable |
| ram_we | output | 1 | RAM write enable |
| cpu_rdata | output | 8 | Read data to the CPU |

## Verification
A wrong control field shows up in the first access of the window it governs, one edge after that access is presented. A stale low or upper bank gives wrong upper bits in rom_addr for a switchable-window access. A wrong mode or upper bank shows as a wrong rom_addr in the fixed window and a wrong ram_addr. A wrong gate shows as a spurious or missing ram_ce, or as 0xFF in place of the array data. Because the bench model is compared on every clock under random programming, with zero, wrap and multicart values among the inputs, such a fault is reported at the first access that touches it.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  localparam logic [7:0] GATE_OPEN_KEY  = 8'h0A;
  localparam logic [7:0] GATE_CLOSE_KEY = 8'h00;
  localparam int         FULL_BANK_W    = 7;

  typedef enum logic [1:0] {
    SEL_GATE  = 2'd0,
    SEL_LOW   = 2'd1,
    SEL_UPPER = 2'd2,
    SEL_MODE  = 2'd3
  } ctl_sel_e;

  typedef struct packed {
    logic       gate;
    logic [4:0] low;
    logic [1:0] upper;
    logic       mode;
  } ctl_state_t;

  // Upper bits placed at their insertion point (bit 5, or bit 4 when multicart)
  function automatic logic [FULL_BANK_W-1:0] place_upper(input logic [1:0] up,
                                                         input logic multi);
    return multi ? {1'b0, up, 4'b0000} : {up, 5'b00000};
  endfunction

endpackage

// File: rtl/cart_ctl_regs.sv
module cart_ctl_regs
  import cart_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       multi_en,
  input  logic       wr,
  input  logic [2:0] addr_hi,
  input  logic [7:0] wdata,
  output ctl_state_t st
);

  logic [4:0] low_next;

  always_comb begin
    low_next = wdata[4:0];
    if (low_next == 5'd0) low_next = 5'd1;
    if (multi_en) low_next[4] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '{gate: 1'b0, low: 5'd1, upper: 2'd0, mode: 1'b0};
    end else if (wr && !addr_hi[2]) begin
      case (ctl_sel_e'(addr_hi[1:0]))
        SEL_GATE: begin
          if (wdata == GATE_OPEN_KEY)       st.gate <= 1'b1;
          else if (wdata == GATE_CLOSE_KEY) st.gate <= 1'b0;
        end
        SEL_LOW:   st.low   <= low_next;
        SEL_UPPER: st.upper <= wdata[1:0];
        SEL_MODE:  st.mode  <= wdata[0];
        default: ;
      endcase
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st.low == 5'd1 && st.upper == 2'd0 && !st.mode && !st.gate)); // R6
  AST_GATE_OPEN: assert property (@(posedge clk) disable iff (rst)
    (wr && addr_hi == 3'b000 && wdata == 8'h0A) |=> st.gate); // R1
  AST_GATE_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (wr && addr_hi == 3'b000 && wdata == 8'h00) |=> !st.gate); // R1
  AST_GATE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr && addr_hi == 3'b000 && wdata != 8'h0A && wdata != 8'h00) |=> $stable(st.gate)); // R1
  AST_LOW_NONZERO: assert property (@(posedge clk) disable iff (rst)
    !multi_en |-> (st.low != 5'd0)); // R2
  AST_LOW_NARROW: assert property (@(posedge clk) disable iff (rst)
    multi_en |-> !st.low[4]); // R2
  AST_HIGH_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr && addr_hi[2]) |=> $stable(st)); // R8

endmodule

// File: rtl/cart_bank_map.sv
module cart_bank_map
  import cart_bank_pkg::*;
#(
  parameter int ROM_BW = 6,
  parameter int RAM_BW = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              multi_en,
  input  ctl_state_t        st,
  output logic [ROM_BW-1:0] hi_bank,
  output logic [ROM_BW-1:0] lo_bank,
  output logic [RAM_BW-1:0] ram_bank
);

  logic [FULL_BANK_W-1:0] up_placed;
  logic [FULL_BANK_W-1:0] low_part;
  logic [FULL_BANK_W-1:0] hi_full;
  logic [FULL_BANK_W-1:0] lo_full;

  always_comb begin
    up_placed = place_upper(st.upper, multi_en);
    low_part  = {2'b00, st.low};
    hi_full   = up_placed | low_part;
    lo_full   = st.mode ? up_placed : '0;
  end

  // Power-of-two sizes: truncation is the wrap
  assign hi_bank  = ROM_BW'(hi_full);
  assign lo_bank  = ROM_BW'(lo_full);
  assign ram_bank = st.mode ? RAM_BW'(st.upper) : '0;

  AST_MODE0_FIXED: assert property (@(posedge clk) disable iff (rst)
    !st.mode |-> (lo_bank == '0 && ram_bank == '0)); // R4
  AST_MODE1_RAM: assert property (@(posedge clk) disable iff (rst)
    st.mode |-> (ram_bank == RAM_BW'(st.upper))); // R4

endmodule

// File: rtl/cart_bus_out.sv
module cart_bus_out #(
  parameter int ROM_BW = 6,
  parameter int RAM_BW = 1,
  localparam int ROM_AW = ROM_BW + 14,
  localparam int RAM_AW = RAM_BW + 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        mem_rdata,
  input  logic              gate,
  input  logic [ROM_BW-1:0] hi_bank,
  input  logic [ROM_BW-1:0] lo_bank,
  input  logic [RAM_BW-1:0] ram_bank,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_ce,
  output logic              ram_we,
  output logic [7:0]        cpu_rdata
);

  logic in_ram_win;
  logic blank_q;
  logic live_q;

  assign in_ram_win = (cpu_addr[15:13] == 3'b101);

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr <= '0;
      ram_addr <= '0;
      ram_ce   <= 1'b0;
      ram_we   <= 1'b0;
      blank_q  <= 1'b0;
      live_q   <= 1'b0;
    end else begin
      rom_addr <= {(cpu_addr[14] ? hi_bank : lo_bank), cpu_addr[13:0]};
      ram_addr <= {ram_bank, cpu_addr[12:0]};
      ram_ce   <= gate && in_ram_win && (cpu_rd || cpu_wr);
      ram_we   <= gate && in_ram_win && cpu_wr;
      blank_q  <= !gate && in_ram_win && cpu_rd;
      live_q   <= 1'b1;
    end
  end

  assign cpu_rdata = blank_q ? 8'hFF : mem_rdata;

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_ce); // R7
  AST_CE_NEEDS_GATE: assert property (@(posedge clk) disable iff (rst)
    ram_ce |-> $past(gate)); // R7
  AST_BLANK_NO_CE: assert property (@(posedge clk) disable iff (rst)
    (cpu_rdata != mem_rdata) |-> !ram_ce); // R7
  AST_ROM_OFFSET: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (rom_addr[13:0] == $past(cpu_addr[13:0]))); // R8

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  parameter int RAM_BANKS = 2,
  localparam int ROM_BW = $clog2(ROM_BANKS),
  localparam int RAM_BW = $clog2(RAM_BANKS),
  localparam int ROM_AW = ROM_BW + 14,
  localparam int RAM_AW = RAM_BW + 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              multi_en,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_ce,
  output logic              ram_we,
  output logic [7:0]        cpu_rdata
);

  ctl_state_t        st;
  logic [ROM_BW-1:0] hi_bank;
  logic [ROM_BW-1:0] lo_bank;
  logic [RAM_BW-1:0] ram_bank;

  cart_ctl_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .multi_en (multi_en),
    .wr       (cpu_wr),
    .addr_hi  (cpu_addr[15:13]),
    .wdata    (cpu_wdata),
    .st       (st)
  );

  cart_bank_map #(.ROM_BW(ROM_BW), .RAM_BW(RAM_BW)) u_map (
    .clk      (clk),
    .rst      (rst),
    .multi_en (multi_en),
    .st       (st),
    .hi_bank  (hi_bank),
    .lo_bank  (lo_bank),
    .ram_bank (ram_bank)
  );

  cart_bus_out #(.ROM_BW(ROM_BW), .RAM_BW(RAM_BW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .mem_rdata (mem_rdata),
    .gate      (st.gate),
    .hi_bank   (hi_bank),
    .lo_bank   (lo_bank),
    .ram_bank  (ram_bank),
    .rom_addr  (rom_addr),
    .ram_addr  (ram_addr),
    .ram_ce    (ram_ce),
    .ram_we    (ram_we),
    .cpu_rdata (cpu_rdata)
  );

endmodule

// File: tb/cart_bank_ctrl_tb_top.sv
module cart_bank_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ROM_BANKS  = 64;
  localparam int RAM_BANKS  = 2;
  localparam int ROM_AW     = $clog2(ROM_BANKS) + 14;
  localparam int RAM_AW     = $clog2(RAM_BANKS) + 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic multi_en = 1'b0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0] cpu_wdata = 8'h0, mem_rdata = 8'h0;
  logic [ROM_AW-1:0] rom_addr;
  logic [RAM_AW-1:0] ram_addr;
  logic ram_ce, ram_we;
  logic [7:0] cpu_rdata;

  int vec_cnt = 0;
  int bad_cnt = 0;
  bit chk_on = 1'b0;

  // behavioural model state
  int m_low, m_up, m_mode, m_gate;
  int e_rom, e_ram, e_ce, e_we, e_blank;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_ctrl #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) dut_i (
    .clk(clk), .rst(rst), .multi_en(multi_en), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .mem_rdata(mem_rdata),
    .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_ce(ram_ce), .ram_we(ram_we),
    .cpu_rdata(cpu_rdata)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_low = 1; m_up = 0; m_mode = 0; m_gate = 0;
      e_rom = 0; e_ram = 0; e_ce = 0; e_we = 0; e_blank = 0;
    end else begin
      int sh, hb, lb, rb, v;
      bit in_ram;
      sh = multi_en ? 4 : 5;
      hb = ((m_up << sh) | m_low) % ROM_BANKS;
      lb = m_mode ? ((m_up << sh) % ROM_BANKS) : 0;
      rb = m_mode ? (m_up % RAM_BANKS) : 0;
      in_ram = (cpu_addr >= 16'hA000 && cpu_addr <= 16'hBFFF);
      e_rom = ((cpu_addr[14] ? hb : lb) * 16384) + (cpu_addr % 16384);
      e_ram = rb * 8192 + (cpu_addr % 8192);
      e_ce = (m_gate != 0 && in_ram && (cpu_rd || cpu_wr)) ? 1 : 0;
      e_we = (e_ce != 0 && cpu_wr) ? 1 : 0;
      e_blank = (m_gate == 0 && in_ram && cpu_rd) ? 1 : 0;
      if (cpu_wr && cpu_addr < 16'h8000) begin
        if (cpu_addr < 16'h2000) begin
          if (cpu_wdata == 8'h0A) m_gate = 1;
          else if (cpu_wdata == 8'h00) m_gate = 0;
        end else if (cpu_addr < 16'h4000) begin
          v = cpu_wdata % 32;
          if (v == 0) v = 1;
          m_low = multi_en ? (v % 16) : v;
        end else if (cpu_addr < 16'h6000) begin
          m_up = cpu_wdata % 4;
        end else begin
          m_mode = cpu_wdata % 2;
        end
      end
    end
  end

  task automatic model_check();
    int e_data;
    e_data = (e_blank != 0) ? 255 : int'(mem_rdata);
    vec_cnt++;
    if (int'(rom_addr) != e_rom || int'(ram_addr) != e_ram || int'(ram_ce) != e_ce ||
        int'(ram_we) != e_we || int'(cpu_rdata) != e_data) begin
      bad_cnt++;
      $display("FAIL R2 R3 R4 R5 R7 R8 model: rom %h/%h ram %h/%h ce %0d/%0d we %0d/%0d rd %h/%h",
               rom_addr, e_rom, ram_addr, e_ram, ram_ce, e_ce, ram_we, e_we, cpu_rdata, e_data);
    end
  endtask

  task automatic cyc(input bit r, input bit w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    if (chk_on) model_check();
    cpu_rd = r; cpu_wr = w; cpu_addr = a; cpu_wdata = d; mem_rdata = 8'($urandom);
  endtask

  // checks the result of the access issued by the previous cyc call
  task automatic lit(input string tag, input int exp_rom, input int exp_ram,
                     input int exp_ce, input int exp_rd);
    @(negedge clk);
    model_check();
    vec_cnt++;
    if ((exp_rom >= 0 && int'(rom_addr) != exp_rom) || (exp_ram >= 0 && int'(ram_addr) != exp_ram) ||
        (exp_ce >= 0 && int'(ram_ce) != exp_ce) || (exp_rd >= 0 && int'(cpu_rdata) != exp_rd)) begin
      bad_cnt++;
      $display("FAIL %s: rom %h/%h ram %h/%h ce %0d/%0d rd %h/%h", tag,
               rom_addr, exp_rom, ram_addr, exp_ram, ram_ce, exp_ce, cpu_rdata, exp_rd);
    end
    cpu_rd = 0; cpu_wr = 0; cpu_addr = 16'h0; mem_rdata = 8'h5A;
  endtask

  task automatic do_reset(input bit multi);
    @(negedge clk);
    chk_on = 0; rst = 1; multi_en = multi; cpu_rd = 0; cpu_wr = 0;
    repeat (3) @(negedge clk);
    rst = 0; chk_on = 1;
  endtask

  task automatic random_phase(input int n);
    for (int i = 0; i < n; i++) begin
      int k;
      logic [7:0] d;
      logic [15:0] a;
      k = $urandom % 10;
      d = 8'($urandom);
      if (($urandom % 4) == 0) d = (($urandom % 2) == 0) ? 8'h0A : 8'h00;
      if (($urandom % 8) == 0) d = 8'h10 | 8'($urandom % 2);
      a = 16'($urandom);
      if (k < 4) cyc(0, 1, {1'b0, 2'(k), a[12:0]}, d);
      else if (k < 6) cyc(1, 0, {1'b0, a[14:0]}, d);
      else if (k < 9) cyc(k == 6, k != 6, {3'b101, a[12:0]}, d);
      else cyc(0, 1, {1'b1, a[14:0]}, d);
    end
  endtask

  initial begin
    // multicart off
    do_reset(0);
    cyc(1, 0, 16'h4000, 8'h00);
    lit("R6 reset bank one", 'h04000, -1, 0, -1);
    cyc(1, 0, 16'hA000, 8'h00);
    lit("R6 R7 reset RAM closed reads FF", -1, 'h0000, 0, 255);
    cyc(0, 1, 16'h2000, 8'h00);
    cyc(1, 0, 16'h4123, 8'h00);
    lit("R2 zero becomes one", 'h04123, -1, -1, -1);
    cyc(0, 1, 16'h2000, 8'h1F);
    cyc(0, 1, 16'h4000, 8'h03);
    cyc(1, 0, 16'h7FFF, 8'h00);
    lit("R3 R5 upper bits and ROM wrap", 'hFFFFF, -1, -1, -1);
    cyc(1, 0, 16'h0010, 8'h00);
    lit("R4 mode0 fixed window bank0", 'h00010, -1, -1, -1);
    cyc(0, 1, 16'h6000, 8'h01);
    cyc(1, 0, 16'h0010, 8'h00);
    lit("R4 mode1 fixed window follows upper", 'h80010, -1, -1, -1);
    cyc(0, 1, 16'h0000, 8'h0A);
    cyc(1, 0, 16'hA005, 8'h00);
    lit("R5 R7 gate open RAM bank wraps", -1, 'h2005, 1, -1);
    cyc(0, 1, 16'h0000, 8'h55);
    cyc(0, 1, 16'hB000, 8'h77);
    lit("R1 other value keeps gate", -1, 'h3000, 1, -1);
    cyc(0, 1, 16'h9000, 8'h00);
    cyc(0, 1, 16'hC000, 8'h00);
    cyc(1, 0, 16'h4000, 8'h00);
    lit("R8 high writes ignored", 'hFC000, -1, -1, -1);
    cyc(0, 1, 16'h0000, 8'h00);
    cyc(1, 0, 16'hA000, 8'h00);
    lit("R1 R7 gate closed reads FF", -1, -1, 0, 255);
    random_phase(4000);

    // multicart on
    do_reset(1);
    cyc(0, 1, 16'h2000, 8'h10);
    cyc(1, 0, 16'h4000, 8'h00);
    lit("R2 multicart mask gives bank0", 'h00000, -1, -1, -1);
    cyc(0, 1, 16'h4000, 8'h02);
    cyc(1, 0, 16'h4001, 8'h00);
    lit("R3 multicart insert at bit4", 'h80001, -1, -1, -1);
    random_phase(4000);

    cyc(0, 0, 16'h0000, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad_cnt++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

endmodule